// File: doc/BRIEF.md
# Port-Limited Rename Map Table

This block holds the speculative architectural-to-physical register mapping for a multi-wide rename stage. Each cycle it receives a group of up to WIDTH decoded instructions. Each instruction may name up to two sources and one destination, and each operand carries a "used" flag and a "dependent" flag. The dependent flag comes from an upstream in-group dependence checker. The table has only RD_PORTS read ports and WR_PORTS write ports, which is fewer than the WIDTH*3 reads and WIDTH writes a worst-case group would need. Ports are handed out only to operands that are used and not dependent. Operands that are dependent take their physical name from the nearest older instruction in the same group that writes that register.

Ports are granted in program order. The first valid instruction whose needs do not fit in the remaining read ports, write ports or free-list entries is held. Every valid instruction younger than it is also held. The block raises a hold signal and reports through a take mask which slots were accepted, so that upstream can present the remaining slots again on a later cycle. Taken destinations consume new physical tags from a free-list interface in order. Their previous mappings are reported so that a later squash can restore them. Results appear one cycle after the group is presented, and the table is updated on the same edge.

Top module: `rename_map_table`

## Requirements
- R1: Reset sets architectural register k to map to physical register k for every k, and clears all result valid bits.
- R2: A taken source operand that is used and not dependent returns the mapping held by the table before the group's own writes.
- R3: A taken slot with a used destination reports its previous mapping in res_dold. The n-th taken destination in slot order (counting from zero) receives fl_tag[n] in res_dnew. fl_pop equals the number of taken destinations.
- R4: After a group is taken, the table holds each new destination tag. When several taken slots write one register, the youngest slot's tag is kept.
- R5: An operand whose used flag is 0 consumes no read port, and its result field is 0.
- R6: An operand that is used and marked dependent consumes no read port. It returns the new tag of the nearest older taken slot in the same group whose destination names the same register.
- R7: A valid slot is taken only if all older valid slots are taken and the total of its read needs and the older slots' read needs is at most RD_PORTS. Once one valid slot is refused, every younger valid slot is refused even if it would fit, and hold is 1.
- R8: The number of taken destinations never exceeds WR_PORTS. The first destination beyond that limit blocks its slot.
- R9: The number of taken destinations never exceeds fl_count. A destination beyond that count blocks its slot.
- R10: A slot that is not taken leaves the table unchanged. Its result has valid 0 and zero fields.
- R11: Slots with in_valid 0 consume no ports, are never taken, and do not raise hold. A group with no valid slot gives take 0, hold 0 and no valid result.
- R12: res_valid on the cycle after a group equals the take mask of that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | WIDTH | Slot holds an instruction |
| in_s1 | input | WIDTH x AW | First source architectural register |
| in_s1_use | input | WIDTH | First source is used |
| in_s1_dep | input | WIDTH | First source depends on an older slot |
| in_s2 | input | WIDTH x AW | Second source architectural register |
| in_s2_use | input | WIDTH | Second source is used |
| in_s2_dep | input | WIDTH | Second source depends on an older slot |
| in_d | input | WIDTH x AW | Destination architectural register |
| in_d_use | input | WIDTH | Destination is used |
| in_d_dep | input | WIDTH | Older slot writes the same destination |
| fl_count | input | CW | Free physical tags available |
| fl_tag | input | WIDTH x PW | Free tags offered, in consumption order |
| take | output | WIDTH | Slots accepted this cycle |
| hold | output | 1 | Some valid slot was refused |
| fl_pop | output | CW | Free tags consumed this cycle |
| res_valid | output | WIDTH | Registered: slot was renamed |
| res_s1 | output | WIDTH x PW | Registered first source physical tag |
| res_s2 | output | WIDTH x PW | Registered second source physical tag |
| res_dold | output | WIDTH x PW | Registered previous destination mapping |
| res_dnew | output | WIDTH x PW | Registered new destination tag |

## Verification
The hardest case to reach from the ports is a refusal that happens while a younger slot would still fit. This requires an exact port budget to be used up by older slots and followed by a cheap or empty instruction. The stimulus fills the twelve read ports with four full instructions and then places a one-read slot and an empty slot behind them. A separate group covers the opposite boundary: four valid three-read slots, spread among invalid slots that advertise heavy demand, use up the read budget exactly. A dependence chain then checks that bypassed operands leave ports free and that the youngest writer of a register is the one kept.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
    // operand positions inside one slot, also the read-port order within it
    localparam int OPS    = 3;
    localparam int OP_S1  = 0;
    localparam int OP_S2  = 1;
    localparam int OP_DST = 2;
endpackage

// File: rtl/rmt_port_alloc.sv
module rmt_port_alloc
    import rmt_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int RD_PORTS = 12,
    parameter int WR_PORTS = 6,
    localparam int RIW = $clog2(OPS*WIDTH+1),
    localparam int CW  = $clog2(WIDTH+1)
) (
    input  logic [WIDTH-1:0]                    slot_valid,
    input  logic [WIDTH-1:0][OPS-1:0]           op_need,
    input  logic [WIDTH-1:0]                    dst_live,
    input  logic [CW-1:0]                       fl_count,
    output logic [WIDTH-1:0]                    take,
    output logic [WIDTH-1:0][OPS-1:0][RIW-1:0]  op_port,
    output logic [WIDTH-1:0][CW-1:0]            slot_wr,
    output logic [CW-1:0]                       pop
);
    always_comb begin
        int   rd_used;
        int   wr_used;
        int   rneed;
        int   wneed;
        logic blocked;
        take    = '0;
        op_port = '0;
        slot_wr = '0;
        rd_used = 0;
        wr_used = 0;
        blocked = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            rneed = 0;
            for (int k = 0; k < OPS; k++) begin
                op_port[i][k] = RIW'(rd_used + rneed);
                if (op_need[i][k]) rneed = rneed + 1;
            end
            wneed      = dst_live[i] ? 1 : 0;
            slot_wr[i] = CW'(wr_used);
            if (slot_valid[i]) begin
                if (!blocked && (rd_used + rneed <= RD_PORTS)
                             && (wr_used + wneed <= WR_PORTS)
                             && (wr_used + wneed <= int'(fl_count))) begin
                    take[i] = 1'b1;
                    rd_used = rd_used + rneed;
                    wr_used = wr_used + wneed;
                end else begin
                    blocked = 1'b1;
                end
            end
        end
        pop = CW'(wr_used);
    end
endmodule

// File: rtl/rmt_read_xbar.sv
module rmt_read_xbar
    import rmt_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 128,
    parameter int RD_PORTS  = 12,
    localparam int AW  = $clog2(ARCH_REGS),
    localparam int PW  = $clog2(PHYS_REGS),
    localparam int RIW = $clog2(OPS*WIDTH+1)
) (
    input  logic [ARCH_REGS-1:0][PW-1:0]        map,
    input  logic [WIDTH-1:0][OPS-1:0][AW-1:0]   op_arch,
    input  logic [WIDTH-1:0][OPS-1:0]           op_rd,
    input  logic [WIDTH-1:0][OPS-1:0][RIW-1:0]  op_port,
    output logic [WIDTH-1:0][OPS-1:0][PW-1:0]   op_data
);
    logic [RD_PORTS-1:0][PW-1:0] port_data;

    // each physical read port picks the operand whose rank equals its number
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        logic [AW-1:0] addr;
        always_comb begin
            addr = '0;
            for (int i = 0; i < WIDTH; i++)
                for (int k = 0; k < OPS; k++)
                    if (op_rd[i][k] && op_port[i][k] == RIW'(p)) addr = op_arch[i][k];
        end
        assign port_data[p] = map[addr];
    end

    always_comb begin
        op_data = '0;
        for (int i = 0; i < WIDTH; i++)
            for (int k = 0; k < OPS; k++)
                for (int p = 0; p < RD_PORTS; p++)
                    if (op_rd[i][k] && op_port[i][k] == RIW'(p)) op_data[i][k] = port_data[p];
    end
endmodule

// File: rtl/rmt_bypass.sv
module rmt_bypass
    import rmt_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 128,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic [WIDTH-1:0][OPS-1:0][AW-1:0]   op_arch,
    input  logic [WIDTH-1:0][OPS-1:0]           op_dep,
    input  logic [WIDTH-1:0][OPS-1:0][PW-1:0]   op_data,
    input  logic [WIDTH-1:0][AW-1:0]            d_arch,
    input  logic [WIDTH-1:0]                    d_live,
    input  logic [WIDTH-1:0][PW-1:0]            new_tag,
    output logic [WIDTH-1:0][OPS-1:0][PW-1:0]   op_val
);
    // a dependent operand takes the newest older in-group writer's tag
    always_comb begin
        op_val = op_data;
        for (int i = 0; i < WIDTH; i++)
            for (int k = 0; k < OPS; k++)
                if (op_dep[i][k]) begin
                    op_val[i][k] = '0;
                    for (int j = 0; j < i; j++)
                        if (d_live[j] && d_arch[j] == op_arch[i][k]) op_val[i][k] = new_tag[j];
                end
    end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
    import rmt_pkg::*;
#(
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 128,
    parameter int WIDTH     = 8,
    parameter int RD_PORTS  = 12,
    parameter int WR_PORTS  = 6,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(WIDTH+1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WIDTH-1:0]            in_valid,
    input  logic [WIDTH-1:0][AW-1:0]    in_s1,
    input  logic [WIDTH-1:0]            in_s1_use,
    input  logic [WIDTH-1:0]            in_s1_dep,
    input  logic [WIDTH-1:0][AW-1:0]    in_s2,
    input  logic [WIDTH-1:0]            in_s2_use,
    input  logic [WIDTH-1:0]            in_s2_dep,
    input  logic [WIDTH-1:0][AW-1:0]    in_d,
    input  logic [WIDTH-1:0]            in_d_use,
    input  logic [WIDTH-1:0]            in_d_dep,
    input  logic [CW-1:0]               fl_count,
    input  logic [WIDTH-1:0][PW-1:0]    fl_tag,
    output logic [WIDTH-1:0]            take,
    output logic                        hold,
    output logic [CW-1:0]               fl_pop,
    output logic [WIDTH-1:0]            res_valid,
    output logic [WIDTH-1:0][PW-1:0]    res_s1,
    output logic [WIDTH-1:0][PW-1:0]    res_s2,
    output logic [WIDTH-1:0][PW-1:0]    res_dold,
    output logic [WIDTH-1:0][PW-1:0]    res_dnew
);
    localparam int RIW = $clog2(OPS*WIDTH+1);

    typedef struct packed {
        logic [ARCH_REGS-1:0][PW-1:0] map;
        logic [WIDTH-1:0]             rv;
        logic [WIDTH-1:0][PW-1:0]     s1;
        logic [WIDTH-1:0][PW-1:0]     s2;
        logic [WIDTH-1:0][PW-1:0]     dold;
        logic [WIDTH-1:0][PW-1:0]     dnew;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int k = 0; k < ARCH_REGS; k++) s.map[k] = PW'(k);
        return s;
    endfunction

    state_t st_d, st_q;

    logic [WIDTH-1:0][OPS-1:0][AW-1:0]   op_arch;
    logic [WIDTH-1:0][OPS-1:0]           op_need;
    logic [WIDTH-1:0][OPS-1:0]           op_dep;
    logic [WIDTH-1:0][OPS-1:0]           op_rd;
    logic [WIDTH-1:0][OPS-1:0]           op_byp;
    logic [WIDTH-1:0]                    dst_live;
    logic [WIDTH-1:0]                    dst_take;
    logic [WIDTH-1:0][OPS-1:0][RIW-1:0]  op_port;
    logic [WIDTH-1:0][CW-1:0]            slot_wr;
    logic [WIDTH-1:0][OPS-1:0][PW-1:0]   rd_data;
    logic [WIDTH-1:0][OPS-1:0][PW-1:0]   op_val;
    logic [WIDTH-1:0][PW-1:0]            new_tag;
    logic [WR_PORTS-1:0]                 wp_en;
    logic [WR_PORTS-1:0][AW-1:0]         wp_addr;
    logic [WR_PORTS-1:0][PW-1:0]         wp_data;
    logic [ARCH_REGS-1:0][PW-1:0]        map_now;

    // operand demand: used, in a valid slot, and not served in-group
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            op_arch[i][OP_S1]  = in_s1[i];
            op_arch[i][OP_S2]  = in_s2[i];
            op_arch[i][OP_DST] = in_d[i];
            op_need[i][OP_S1]  = in_valid[i] & in_s1_use[i] & ~in_s1_dep[i];
            op_need[i][OP_S2]  = in_valid[i] & in_s2_use[i] & ~in_s2_dep[i];
            op_need[i][OP_DST] = in_valid[i] & in_d_use[i]  & ~in_d_dep[i];
            op_dep[i][OP_S1]   = in_valid[i] & in_s1_use[i] & in_s1_dep[i];
            op_dep[i][OP_S2]   = in_valid[i] & in_s2_use[i] & in_s2_dep[i];
            op_dep[i][OP_DST]  = in_valid[i] & in_d_use[i]  & in_d_dep[i];
            dst_live[i]        = in_valid[i] & in_d_use[i];
        end
    end

    rmt_port_alloc #(
        .WIDTH(WIDTH), .RD_PORTS(RD_PORTS), .WR_PORTS(WR_PORTS)
    ) u_alloc (
        .slot_valid(in_valid),
        .op_need   (op_need),
        .dst_live  (dst_live),
        .fl_count  (fl_count),
        .take      (take),
        .op_port   (op_port),
        .slot_wr   (slot_wr),
        .pop       (fl_pop)
    );

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            op_rd[i]    = op_need[i] & {OPS{take[i]}};
            op_byp[i]   = op_dep[i]  & {OPS{take[i]}};
            dst_take[i] = dst_live[i] & take[i];
            new_tag[i]  = '0;
            for (int q = 0; q < WIDTH; q++)
                if (slot_wr[i] == CW'(q)) new_tag[i] = fl_tag[q];
        end
    end

    rmt_read_xbar #(
        .WIDTH(WIDTH), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .RD_PORTS(RD_PORTS)
    ) u_xbar (
        .map    (st_q.map),
        .op_arch(op_arch),
        .op_rd  (op_rd),
        .op_port(op_port),
        .op_data(rd_data)
    );

    rmt_bypass #(
        .WIDTH(WIDTH), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)
    ) u_byp (
        .op_arch(op_arch),
        .op_dep (op_byp),
        .op_data(rd_data),
        .d_arch (in_d),
        .d_live (dst_take),
        .new_tag(new_tag),
        .op_val (op_val)
    );

    // write port q carries the q-th taken destination; higher q is younger
    always_comb begin
        wp_en   = '0;
        wp_addr = '0;
        wp_data = '0;
        for (int q = 0; q < WR_PORTS; q++) begin
            wp_data[q] = (q < WIDTH) ? fl_tag[q] : '0;
            for (int i = 0; i < WIDTH; i++)
                if (dst_take[i] && slot_wr[i] == CW'(q)) begin
                    wp_en[q]   = 1'b1;
                    wp_addr[q] = in_d[i];
                end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int q = 0; q < WR_PORTS; q++)
            if (wp_en[q]) st_d.map[wp_addr[q]] = wp_data[q];
        for (int i = 0; i < WIDTH; i++) begin
            st_d.rv[i]   = take[i];
            st_d.s1[i]   = take[i]     ? op_val[i][OP_S1]  : '0;
            st_d.s2[i]   = take[i]     ? op_val[i][OP_S2]  : '0;
            st_d.dold[i] = dst_take[i] ? op_val[i][OP_DST] : '0;
            st_d.dnew[i] = dst_take[i] ? new_tag[i]        : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign hold      = |(in_valid & ~take);
    assign res_valid = st_q.rv;
    assign res_s1    = st_q.s1;
    assign res_s2    = st_q.s2;
    assign res_dold  = st_q.dold;
    assign res_dnew  = st_q.dnew;
    assign map_now   = st_q.map;
endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 128,
    parameter int WIDTH     = 8,
    parameter int RD_PORTS  = 12,
    parameter int WR_PORTS  = 6,
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(WIDTH+1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [WIDTH-1:0]             in_valid,
    input logic [WIDTH-1:0]             in_s1_use,
    input logic [WIDTH-1:0]             in_s1_dep,
    input logic [WIDTH-1:0]             in_s2_use,
    input logic [WIDTH-1:0]             in_s2_dep,
    input logic [WIDTH-1:0]             in_d_use,
    input logic [WIDTH-1:0]             in_d_dep,
    input logic [CW-1:0]                fl_count,
    input logic [WIDTH-1:0]             take,
    input logic                         hold,
    input logic [CW-1:0]                fl_pop,
    input logic [WIDTH-1:0]             res_valid,
    input logic [ARCH_REGS-1:0][PW-1:0] map_q
);
    int   rd_cnt;
    int   wr_cnt;
    logic gap;

    always_comb begin
        logic refused;
        rd_cnt  = 0;
        wr_cnt  = 0;
        gap     = 1'b0;
        refused = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (in_valid[i]) begin
                if (!take[i]) refused = 1'b1;
                else if (refused) gap = 1'b1;
            end
            if (in_valid[i] && take[i]) begin
                rd_cnt = rd_cnt + ((in_s1_use[i] && !in_s1_dep[i]) ? 1 : 0)
                                + ((in_s2_use[i] && !in_s2_dep[i]) ? 1 : 0)
                                + ((in_d_use[i]  && !in_d_dep[i])  ? 1 : 0);
                wr_cnt = wr_cnt + (in_d_use[i] ? 1 : 0);
            end
        end
    end

    AST_TAKE_PREFIX:   assert property (@(posedge clk) disable iff (!rst_n) !gap);                          // R7
    AST_READ_BUDGET:   assert property (@(posedge clk) disable iff (!rst_n) rd_cnt <= RD_PORTS);            // R7
    AST_WRITE_BUDGET:  assert property (@(posedge clk) disable iff (!rst_n) wr_cnt <= WR_PORTS);            // R8
    AST_POP_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) fl_pop <= fl_count);            // R9
    AST_POP_COUNT:     assert property (@(posedge clk) disable iff (!rst_n) int'(fl_pop) == wr_cnt);        // R3
    AST_TAKE_VALID:    assert property (@(posedge clk) disable iff (!rst_n) (take & ~in_valid) == '0);      // R11
    AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) (in_valid == '0) |-> !hold);    // R11
    AST_IDLE_NO_RES:   assert property (@(posedge clk) disable iff (!rst_n) (in_valid == '0) |=> (res_valid == '0)); // R11
    AST_MAP_STABLE:    assert property (@(posedge clk) disable iff (!rst_n) (wr_cnt == 0) |=> $stable(map_q)); // R10
    AST_RES_FOLLOWS:   assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (res_valid == $past(take))); // R12
endmodule

bind rename_map_table rmt_checker #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .WIDTH(WIDTH),
    .RD_PORTS(RD_PORTS), .WR_PORTS(WR_PORTS)
) u_rmt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_s1_use(in_s1_use),
    .in_s1_dep(in_s1_dep),
    .in_s2_use(in_s2_use),
    .in_s2_dep(in_s2_dep),
    .in_d_use (in_d_use),
    .in_d_dep (in_d_dep),
    .fl_count (fl_count),
    .take     (take),
    .hold     (hold),
    .fl_pop   (fl_pop),
    .res_valid(res_valid),
    .map_q    (map_now)
);

// File: tb/rename_map_table_bench.sv
module rename_map_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int NA = 32;
    localparam int AW = 5;
    localparam int PW = 7;
    localparam int CW = 4;
    localparam int RD = 12;
    localparam int WR = 6;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [W-1:0]            in_valid;
    logic [W-1:0][AW-1:0]    in_s1, in_s2, in_d;
    logic [W-1:0]            in_s1_use, in_s1_dep, in_s2_use, in_s2_dep, in_d_use, in_d_dep;
    logic [CW-1:0]           fl_count;
    logic [W-1:0][PW-1:0]    fl_tag;
    logic [W-1:0]            take;
    logic                    hold;
    logic [CW-1:0]           fl_pop;
    logic [W-1:0]            res_valid;
    logic [W-1:0][PW-1:0]    res_s1, res_s2, res_dold, res_dnew;

    int checks = 0;
    int fails  = 0;
    int tag_base = 0;
    int mdl  [NA];
    int e_take[W], e_s1[W], e_s2[W], e_do[W], e_dn[W];

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_map_table u_rename_map_table (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        in_valid = '0; in_s1 = '0; in_s2 = '0; in_d = '0;
        in_s1_use = '0; in_s1_dep = '0; in_s2_use = '0; in_s2_dep = '0;
        in_d_use = '0; in_d_dep = '0;
        fl_count = CW'(W);
        for (int q = 0; q < W; q++) fl_tag[q] = PW'(32 + ((tag_base + q) % 96));
    endtask

    task automatic set_slot(input int i, input int s1, input int u1, input int p1,
                            input int s2, input int u2, input int p2,
                            input int d, input int ud, input int pd);
        in_valid[i] = 1'b1;
        in_s1[i] = AW'(s1); in_s1_use[i] = u1[0]; in_s1_dep[i] = p1[0];
        in_s2[i] = AW'(s2); in_s2_use[i] = u2[0]; in_s2_dep[i] = p2[0];
        in_d[i]  = AW'(d);  in_d_use[i]  = ud[0]; in_d_dep[i]  = pd[0];
    endtask

    function automatic int older_tag(input int i, input int a);
        int r = 0;
        for (int j = 0; j < i; j++)
            if (e_take[j] == 1 && in_d_use[j] && int'(in_d[j]) == a) r = e_dn[j];
        return r;
    endfunction

    // apply the group presented now, check grants, then results one edge later
    task automatic run_group(input string lbl);
        int rd, wr, rn, wn, exp_hold;
        bit blk;
        #1;
        rd = 0; wr = 0; blk = 0; exp_hold = 0;
        for (int i = 0; i < W; i++) begin
            e_take[i] = 0; e_s1[i] = 0; e_s2[i] = 0; e_do[i] = 0; e_dn[i] = 0;
            if (in_valid[i]) begin
                rn = ((in_s1_use[i] && !in_s1_dep[i]) ? 1 : 0)
                   + ((in_s2_use[i] && !in_s2_dep[i]) ? 1 : 0)
                   + ((in_d_use[i]  && !in_d_dep[i])  ? 1 : 0);
                wn = in_d_use[i] ? 1 : 0;
                if (!blk && rd + rn <= RD && wr + wn <= WR && wr + wn <= int'(fl_count)) begin
                    e_take[i] = 1;
                    if (in_s1_use[i]) e_s1[i] = in_s1_dep[i] ? older_tag(i, int'(in_s1[i])) : mdl[in_s1[i]];
                    if (in_s2_use[i]) e_s2[i] = in_s2_dep[i] ? older_tag(i, int'(in_s2[i])) : mdl[in_s2[i]];
                    if (in_d_use[i]) begin
                        e_do[i] = in_d_dep[i] ? older_tag(i, int'(in_d[i])) : mdl[in_d[i]];
                        e_dn[i] = int'(fl_tag[wr]);
                    end
                    rd += rn; wr += wn;
                end else begin
                    blk = 1; exp_hold = 1;
                end
            end
        end
        for (int i = 0; i < W; i++) chk(lbl, $sformatf("take[%0d]", i), int'(take[i]), e_take[i]);
        chk(lbl, "hold", int'(hold), exp_hold);
        chk("R3", "fl_pop", int'(fl_pop), wr);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < W; i++) begin
            string q;
            q = (e_take[i] == 1) ? "R12" : "R10";
            chk(q, $sformatf("res_valid[%0d]", i), int'(res_valid[i]), e_take[i]);
            q = (e_take[i] == 0) ? "R10" : (!in_s1_use[i] ? "R5" : (in_s1_dep[i] ? "R6" : "R2"));
            chk(q, $sformatf("res_s1[%0d]", i), int'(res_s1[i]), e_s1[i]);
            q = (e_take[i] == 0) ? "R10" : (!in_s2_use[i] ? "R5" : (in_s2_dep[i] ? "R6" : "R2"));
            chk(q, $sformatf("res_s2[%0d]", i), int'(res_s2[i]), e_s2[i]);
            q = (e_take[i] == 0) ? "R10" : (in_d_dep[i] ? "R6" : "R3");
            chk(q, $sformatf("res_dold[%0d]", i), int'(res_dold[i]), e_do[i]);
            chk((e_take[i] == 0) ? "R10" : "R3", $sformatf("res_dnew[%0d]", i), int'(res_dnew[i]), e_dn[i]);
        end
        for (int i = 0; i < W; i++)
            if (e_take[i] == 1 && in_d_use[i]) mdl[in_d[i]] = e_dn[i];
        tag_base += W;
        clear_inputs();
    endtask

    // R1: every architectural register reads back as itself after reset
    task automatic t_reset_map();
        for (int g = 0; g < NA / W; g++) begin
            for (int i = 0; i < W; i++) set_slot(i, g*W + i, 1, 0, 0, 0, 0, 0, 0, 0);
            run_group("R1");
        end
    endtask

    // R5: only one operand used per slot, the rest carry junk with use=0
    task automatic t_sparse();
        for (int i = 0; i < W; i++) set_slot(i, 31 - i, 0, 1, 3 + i, 1, 0, 17, 0, 1);
        run_group("R5");
    endtask

    // R7/R10: full demand, four slots use all twelve read ports
    task automatic t_read_overflow();
        for (int i = 0; i < W; i++) set_slot(i, i, 1, 0, i + 8, 1, 0, 16 + i, 1, 0);
        run_group("R7");
        for (int i = 0; i < W; i++) set_slot(i, 16 + i, 1, 0, 0, 0, 0, 0, 0, 0);
        run_group("R4");
    endtask

    // R7: a cheap slot and an empty slot behind a refusal stay refused
    task automatic t_blocked_nop();
        for (int i = 0; i < 4; i++) set_slot(i, i + 1, 1, 0, i + 5, 1, 0, 9 + i, 1, 0);
        set_slot(4, 2, 1, 0, 0, 0, 0, 0, 0, 0);
        set_slot(5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_group("R7");
    endtask

    // R8: eight destinations, write ports limit to six
    task automatic t_write_limit();
        for (int i = 0; i < W; i++) set_slot(i, 0, 0, 0, 0, 0, 0, 24 + i, 1, 0);
        run_group("R8");
    endtask

    // R9: free list offers only three tags
    task automatic t_fl_short();
        for (int i = 0; i < W; i++) set_slot(i, 0, 0, 0, 0, 0, 0, 20 + i, 1, 0);
        fl_count = CW'(3);
        run_group("R9");
    endtask

    // R6/R4: chain of writers of register 3 with dependent readers
    task automatic t_dep_chain();
        set_slot(0, 1, 1, 0, 2, 1, 0, 3, 1, 0);
        for (int i = 1; i < 5; i++) set_slot(i, 3, 1, 1, 10 + i, 1, 0, 3, 1, 1);
        for (int i = 5; i < W; i++) set_slot(i, 3, 1, 1, 10 + i, 1, 0, 0, 0, 0);
        run_group("R6");
        set_slot(0, 3, 1, 0, 0, 0, 0, 0, 0, 0);
        run_group("R4");
    endtask

    // R11: invalid slots advertise heavy demand; valid ones use exactly twelve reads
    task automatic t_holes();
        for (int i = 0; i < W; i++) set_slot(i, i, 1, 0, 7 + i, 1, 0, 14 + i, 1, 0);
        for (int i = 0; i < W; i += 2) in_valid[i] = 1'b0;
        run_group("R11");
        for (int i = 0; i < W; i++) set_slot(i, i, 1, 0, i, 1, 0, i, 1, 0);
        in_valid = '0;
        run_group("R11");
    endtask

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        for (int k = 0; k < NA; k++) mdl[k] = k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "res_valid after reset", int'(res_valid), 0);
        t_reset_map();
        t_sparse();
        t_read_overflow();
        t_blocked_nop();
        t_write_limit();
        t_fl_short();
        t_dep_chain();
        t_holes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule